// File: doc/BRIEF.md
# Multiphase Event Bit-Plane Deserializer

This block watches a bank of one-bit event lines, such as comparator outputs, and samples every line on each edge of one fast clock. Each event is therefore placed in time to within one fast-clock period. A divide-by-five counter marks a frame of five fast cycles. A chain of four fast-clock registers then delays that frame marker, one cycle per stage, to give five slot enables. Each enable picks which slot of the frame the current sample belongs to.

The samples are regrouped as bit-planes. For every slot there is one word, and bit c of that word is channel c. All channels therefore share one time base by construction. One frame word of five planes appears on a valid/ready output once per frame. A build option pairs two consecutive frames into one double-width word at half the frame rate.

The input cannot be paused, so the output cannot stall the capture. A word that has not been accepted stays on `out_data` with `out_valid` high. If the next word arrives before it is accepted, the new word replaces it. A handshake happens at a rising edge where `out_valid` and `out_ready` are both high. After that edge `out_valid` drops, unless a new word is loaded at the same edge.

Top module: `event_plane_deser`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `slot_phase` is 0. After release, `slot_phase` stays 0 through the first four rising edges, and no word is presented before the 10th rising edge.
- R2: From the 5th rising edge after release onward, `slot_phase` is one-hot. After edge e, bit ((e-5) mod NSLOT) is set, so each bit lags the bit below it by exactly one fast cycle and repeats every NSLOT cycles.
- R3: In each frame word, bit [s*NCH + c] is the value of channel c sampled in slot s, with slot 0 in the lowest NCH bits. Frame f takes slot s from rising edge 6 + 5f + s after release.
- R4: The word for frame f is loaded at rising edge 10 + 5f, with `out_valid` set. Every fast cycle is captured, with no gap between frames.
- R5: Events on adjacent channels that are one fast cycle apart are both captured, each in its own channel bit and slot. This also holds across a frame boundary.
- R6: With `out_ready` low, `out_valid` and `out_data` hold until a newer word replaces them. A handshake with no new word loaded at the same edge clears `out_valid`.
- R7: With DEMUX2=1, the output is 2*NCH*NSLOT bits wide and is loaded once every two frames, at rising edge 15 + 10k. Frame 2k sits in the lower half and frame 2k+1 in the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | NCH | One event line per channel, sampled on every rising edge |
| slot_phase | output | NSLOT | One-hot slot enables, bit s active during slot s |
| out_data | output | NCH*NSLOT*(DEMUX2+1) | Bit-plane frame word, slot 0 in the lowest bits |
| out_valid | output | 1 | A word is presented on `out_data` |
| out_ready | input | 1 | The consumer accepts the presented word |

## Verification
The hardest case to reach is two events on neighbouring channels exactly one fast cycle apart, where one lands in slot 4 of one frame and the other in slot 0 of the next. A single pairing of slots would miss the frame seam. The stimulus table therefore walks a one-cycle pulse staircase across all channels for more than one frame length, so every slot and the seam are each hit by an adjacent pair. Random sparse pulses of widths 1 to 3 on all lines are then run with a randomly gated `out_ready`, so that held words and overwritten words both occur.

// File: rtl/evdes_pkg.sv
package evdes_pkg;
  localparam int EVDES_NCH_DEF   = 16;
  localparam int EVDES_NSLOT_DEF = 5;

  function automatic int evdes_out_width(input int nch, input int nslot, input int demux2);
    return nch * nslot * (demux2 != 0 ? 2 : 1);
  endfunction
endpackage

// File: rtl/evdes_phase_gen.sv
module evdes_phase_gen #(
  parameter int NSLOT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [NSLOT-1:0] phase
);
  localparam int CW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [CW-1:0] LAST = CW'(NSLOT - 1);

  logic [CW-1:0] div_cnt;

  // divide-by-NSLOT counter on the fast clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_cnt <= '0;
    else if (div_cnt == LAST)  div_cnt <= '0;
    else                       div_cnt <= div_cnt + 1'b1;
  end

  // phase 0 is the registered frame marker, the other taps delay it one cycle each
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase[0] <= 1'b0;
    else        phase[0] <= (div_cnt == LAST);
  end

  for (genvar k = 1; k < NSLOT; k++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase[k] <= 1'b0;
      else        phase[k] <= phase[k-1];
    end
    p_tap_lag_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      phase[k-1] |=> phase[k]);
  end

  p_onehot_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase));
  p_no_repeat_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] |=> !phase[0]);
endmodule

// File: rtl/evdes_slot_capture.sv
module evdes_slot_capture #(
  parameter int NCH   = 16,
  parameter int NSLOT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       din,
  input  logic [NSLOT-1:0]     phase,
  output logic [NCH*NSLOT-1:0] frame_word,
  output logic                 frame_stb
);
  // the last slot is taken straight from din at the closing edge
  logic [NCH-1:0] plane [NSLOT-1];

  for (genvar s = 0; s < NSLOT - 1; s++) begin : g_plane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        plane[s] <= '0;
      else if (phase[s]) plane[s] <= din;
    end
    assign frame_word[s*NCH +: NCH] = plane[s];
  end
  assign frame_word[(NSLOT-1)*NCH +: NCH] = din;
  assign frame_stb = phase[NSLOT-1];

  p_stb_spacing_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb);
endmodule

// File: rtl/evdes_out_stage.sv
module evdes_out_stage #(
  parameter int IW     = 80,
  parameter int DEMUX2 = 0,
  localparam int OW    = IW * (DEMUX2 != 0 ? 2 : 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] in_word,
  input  logic          in_stb,
  input  logic          out_ready,
  output logic [OW-1:0] out_data,
  output logic          out_valid
);
  logic          load;
  logic [OW-1:0] word;

  if (DEMUX2 != 0) begin : g_pair
    logic [IW-1:0] early_q;
    logic          second_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        early_q  <= '0;
        second_q <= 1'b0;
      end else if (in_stb) begin
        if (!second_q) early_q <= in_word;
        second_q <= ~second_q;
      end
    end
    assign load = in_stb & second_q;
    assign word = {in_word, early_q};
    p_pair_gap_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);
  end else begin : g_single
    assign load = in_stb;
    assign word = in_word;
  end

  // no stall possible: a new word replaces one not yet taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (load) begin
      out_data  <= word;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_data)));
  p_drop_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid);
endmodule

// File: rtl/event_plane_deser.sv
module event_plane_deser
  import evdes_pkg::*;
#(
  parameter int NCH    = EVDES_NCH_DEF,
  parameter int NSLOT  = EVDES_NSLOT_DEF,
  parameter int DEMUX2 = 0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NCH-1:0]                    din,
  output logic [NSLOT-1:0]                  slot_phase,
  output logic [NCH*NSLOT*(DEMUX2+1)-1:0]   out_data,
  output logic                              out_valid,
  input  logic                              out_ready
);
  localparam int FW = NCH * NSLOT;
  localparam int OW = evdes_out_width(NCH, NSLOT, DEMUX2);

  logic [FW-1:0] frame_word;
  logic          frame_stb;
  logic [OW-1:0] data_int;

  evdes_phase_gen #(.NSLOT(NSLOT)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(slot_phase)
  );

  evdes_slot_capture #(.NCH(NCH), .NSLOT(NSLOT)) u_capture (
    .clk(clk), .rst_n(rst_n), .din(din), .phase(slot_phase),
    .frame_word(frame_word), .frame_stb(frame_stb)
  );

  evdes_out_stage #(.IW(FW), .DEMUX2(DEMUX2)) u_out (
    .clk(clk), .rst_n(rst_n), .in_word(frame_word), .in_stb(frame_stb),
    .out_ready(out_ready), .out_data(data_int), .out_valid(out_valid)
  );

  assign out_data = data_int;

  p_first_word_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_stb));
endmodule

// File: tb/event_plane_deser_tb_top.sv
module event_plane_deser_tb_top;
  localparam int NCH = 16;
  localparam int NSL = 5;
  localparam int FW  = NCH * NSL;
  localparam int HN  = 8192;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n = 1'b0;
  logic [NCH-1:0]  din = '0;
  logic            rdy1 = 1'b1;
  logic [NSL-1:0]  ph1, ph2;
  logic [FW-1:0]   out1;
  logic [2*FW-1:0] out2;
  logic            v1, v2;

  event_plane_deser #(.NCH(NCH), .NSLOT(NSL), .DEMUX2(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .slot_phase(ph1),
    .out_data(out1), .out_valid(v1), .out_ready(rdy1));

  event_plane_deser #(.NCH(NCH), .NSLOT(NSL), .DEMUX2(1)) dut2_i (
    .clk(clk), .rst_n(rst_n), .din(din), .slot_phase(ph2),
    .out_data(out2), .out_valid(v2), .out_ready(1'b1));

  int nchk = 0, nfail = 0, cyc = 0, ecnt = 0;
  bit done = 0, adj = 0, ev = 0;
  logic [NCH-1:0] hist [0:HN-1];
  logic           rhist[0:HN-1];

  // record what each edge sampled
  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else if (ecnt < HN - 1) begin
      hist[ecnt+1]  <= din;
      rhist[ecnt+1] <= rdy1;
      ecnt <= ecnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [2*FW-1:0] act, input logic [2*FW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", req, act, exp, ecnt);
    end
  endtask

  function automatic logic [FW-1:0] frame_exp(input int f);
    logic [FW-1:0] w;
    for (int s = 0; s < NSL; s++)
      for (int c = 0; c < NCH; c++)
        w[s*NCH+c] = hist[6+5*f+s][c];
    return w;
  endfunction

  // reference model and comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) ev = 0;
    else if (!done) begin
      int e;
      logic [NSL-1:0] eph;
      e = ecnt;
      eph = (e >= 5) ? (NSL'(1) << ((e - 5) % 5)) : '0;
      chk(ph1 == eph, (e < 10) ? "R1 phase" : "R2 phase", 160'(ph1), 160'(eph));
      if (e >= 10 && (e - 10) % 5 == 0) ev = 1;
      else if (e >= 1 && rhist[e] && ev) ev = 0;
      chk(v1 == ev, (e < 10) ? "R1 valid" : "R4/R6 valid", 160'(v1), 160'(ev));
      if (ev && v1) begin
        logic [FW-1:0] x;
        x = frame_exp((e - 10) / 5);
        chk(out1 == x, adj ? "R5 data" : "R3 data", 160'(out1), 160'(x));
      end
      begin
        bit n2;
        n2 = (e >= 15 && (e - 15) % 10 == 0);
        chk(v2 == n2, "R7 valid", 160'(v2), 160'(n2));
        if (n2 && v2) begin
          logic [2*FW-1:0] y;
          y = {frame_exp(2*((e-15)/10)+1), frame_exp(2*((e-15)/10))};
          chk(out2 == y, "R7 data", out2, y);
        end
      end
    end
  end

  // stimulus table: {din, cycles}; one-cycle staircase covers adjacent-channel pairs
  localparam logic [23:0] VEC [0:23] = '{
    {16'h0001, 8'd1}, {16'h0002, 8'd1}, {16'h0004, 8'd1}, {16'h0008, 8'd1},
    {16'h0010, 8'd1}, {16'h0020, 8'd1}, {16'h0040, 8'd1}, {16'h0080, 8'd1},
    {16'h0100, 8'd1}, {16'h0200, 8'd1}, {16'h0400, 8'd1}, {16'h0800, 8'd1},
    {16'h1000, 8'd1}, {16'h2000, 8'd1}, {16'h4000, 8'd1}, {16'h8000, 8'd1},
    {16'h0000, 8'd3}, {16'hFFFF, 8'd2}, {16'h0000, 8'd4}, {16'hA5A5, 8'd1},
    {16'h5A5A, 8'd1}, {16'h0003, 8'd7}, {16'h0000, 8'd6}, {16'h8001, 8'd5}};

  task automatic drive(input logic [NCH-1:0] d);
    @(negedge clk);
    din = d;
  endtask

  task automatic run_random(input int n, input bit rand_rdy);
    int left [NCH];
    for (int c = 0; c < NCH; c++) left[c] = 0;
    for (int i = 0; i < n; i++) begin
      logic [NCH-1:0] d;
      for (int c = 0; c < NCH; c++) begin
        if (left[c] == 0 && ($urandom % 10) == 0) left[c] = 1 + ($urandom % 3);
        d[c] = (left[c] != 0);
        if (left[c] != 0) left[c]--;
      end
      @(negedge clk);
      din = d;
      rdy1 = rand_rdy ? (($urandom % 3) != 0) : 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(v1 == 1'b0, "R1 reset valid", 160'(v1), 160'(0));
    chk(ph1 == '0, "R1 reset phase", 160'(ph1), 160'(0));
    rst_n = 1'b1;
    adj = 1;
    for (int r = 0; r < 3; r++)
      foreach (VEC[i])
        for (int k = 0; k < int'(VEC[i][7:0]); k++) drive(VEC[i][23:8]);
    adj = 0;
    run_random(600, 1'b0);
    run_random(1200, 1'b1);
    // long stall: R6 hold and overwrite
    @(negedge clk); rdy1 = 1'b0;
    run_random(1, 1'b0);
    rdy1 = 1'b0;
    repeat (23) drive(16'h1248);
    rdy1 = 1'b1;
    repeat (12) drive('0);
    // reset in mid-frame, then restart
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(v1 == 1'b0 && v2 == 1'b0, "R1 mid reset valid", 160'({v1, v2}), 160'(0));
    chk(ph1 == '0 && ph2 == '0, "R1 mid reset phase", 160'({ph1, ph2}), 160'(0));
    rst_n = 1'b1;
    adj = 1;
    foreach (VEC[i])
      for (int k = 0; k < int'(VEC[i][7:0]); k++) drive(VEC[i][23:8]);
    adj = 0;
    run_random(400, 1'b1);
    repeat (25) drive('0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule